// File: doc/BRIEF.md
# Sequencer Start Trigger Generator

This block decides when a timing sequencer may begin a new sequence. It holds one 16-bit control word, written and read over a simple register port in the fast clock domain. From that word it produces a single-cycle start pulse. The pulse can be sourced in four ways:

- from a programmable divider clocked by a free-running slow clock;
- from a software start bit;
- from either of those two;
- from nothing at all, in the halt setting.

An optional repeat setting restarts the sequencer as soon as it reports that the previous sequence has finished.

The divider is built from two odd-ratio stages and a final toggle stage. Its ratio is twice the product of two odd numbers, 2A+1 and 2B+1, where A and B are 3-bit fields. The slow clock arrives asynchronously and is brought into the fast domain through a synchroniser and an edge detector. A software start therefore lines up with the next slow-clock edge.

Two prescalers run beside the trigger path. One produces a clock enable for the sequencer from the fast clock. The other produces a divided enable from the slow clock.

Top module: `seq_trigger_gen`

## Requirements
- R1: After reset every control field is 0, the register reads 0x0000 and no start pulse is issued. Writes are stored as laid out below and read back unchanged, except bit 15, which always reads 0. The layout is:
  - bit 14: function-select bit;
  - bits 13:12: trigger source;
  - bit 11: software start;
  - bit 10: repeat;
  - bits 9:7: B;
  - bits 6:4: A;
  - bits 3:2: slow prescaler;
  - bits 1:0: fast prescaler.
- R2: With trigger source 01 (divider only) and the sequencer idle, consecutive start pulses are exactly (2A+1)*(2B+1)*2 slow-clock rising edges apart. This gives 2 for A=B=0 and 450 for A=B=7.
- R3: A write that changes A or B restarts the divider. The first pulse then comes (2A+1)*(2B+1) slow-clock edges after the write, give or take one edge.
- R4: Trigger source 00 (halt) issues no start pulse, whatever the software start and repeat bits hold and whatever the busy input does.
- R5: With trigger source 10 (software only), writing bit 11 as 1 gives one start pulse no later than one slow-clock period plus two fast-clock cycles after the write. No divider pulses appear in this setting.
- R6: Bit 11 clears itself in the cycle in which any start pulse is issued. With trigger source 01 the bit has no effect and stays set until a start occurs.
- R7: With trigger source 11, both a software start and the divider produce pulses, and the divider keeps its R2 period.
- R8: While seq_busy_i is high no start pulse is issued. A divider trigger that falls inside a busy window is dropped rather than delayed, so later pulses stay on the divider's period grid.
- R9: With bit 10 set and the trigger source not 00, a falling edge on seq_busy_i produces a start pulse in the next fast-clock cycle. With bit 10 clear, a falling busy edge produces no pulse.
- R10: seq_clk_en_o is high on one fast-clock cycle in every 1, 2, 4 or 8, selected by bits 1:0 as 00 to 11.
- R11: slow_clk_en_o is high for one fast cycle on one slow-clock edge in every 1, 2, 4 or 8, selected by bits 3:2 as 00 to 11.
- R12: Every start pulse lasts exactly one fast-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock; the register port and all logic run on it |
| rst_ni | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside the block |
| slow_clk_i | input | 1 | Free-running slow clock, asynchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Current register contents |
| seq_busy_i | input | 1 | High while the sequencer runs a sequence |
| start_o | output | 1 | Single-cycle start pulse to the sequencer |
| seq_clk_en_o | output | 1 | Prescaled fast-clock enable for the sequencer |
| slow_clk_en_o | output | 1 | Prescaled slow-clock enable |

## Verification
The bench builds the block with its default parameters: two 3-bit odd-stage fields, 2-bit prescaler selects and a two-flop synchroniser. With these values, all 64 (A, B) pairs and the full ratio range from 2 to 450 can be covered exhaustively. The bench visits the pairs in a seeded pseudo-random order with random prescaler settings. For each pair it measures both the restart latency and the steady period in slow-clock edges. Directed cases then cover the following:
- busy windows that straddle a divider trigger;
- repeat restarts after busy windows of random length;
- software starts at random phases;
- every prescaler setting.

// File: rtl/seq_trig_pkg.sv
package seq_trig_pkg;

  localparam int REG_W = 16;
  localparam int DIV_W = 3;
  localparam int PRE_W = 2;

  typedef enum logic [1:0] {
    MODE_HALT = 2'b00,
    MODE_DIV  = 2'b01,
    MODE_SW   = 2'b10,
    MODE_ANY  = 2'b11
  } trig_mode_e;

  // Field order follows the register bit positions, MSB first (bits 14..0)
  typedef struct packed {
    logic             fsel;
    trig_mode_e       mode;
    logic             sw_start;
    logic             repeat_en;
    logic [DIV_W-1:0] div_b;
    logic [DIV_W-1:0] div_a;
    logic [PRE_W-1:0] slow_pre;
    logic [PRE_W-1:0] fast_pre;
  } trig_cfg_t;

endpackage

// File: rtl/seq_trig_regs.sv
module seq_trig_regs
  import seq_trig_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             sw_clr_i,
  output trig_mode_e       mode_o,
  output logic             sw_start_o,
  output logic             repeat_o,
  output logic [DIV_W-1:0] div_a_o,
  output logic [DIV_W-1:0] div_b_o,
  output logic [PRE_W-1:0] slow_pre_o,
  output logic [PRE_W-1:0] fast_pre_o,
  output logic             div_chg_o,
  output logic [REG_W-1:0] rd_data_o
);

  trig_cfg_t cfg_q, cfg_d, wr_cfg;
  logic      unused_rsvd;

  assign wr_cfg      = trig_cfg_t'(wr_data_i[REG_W-2:0]);
  assign unused_rsvd = wr_data_i[REG_W-1];

  // next state: a write wins over the self-clear of the start bit
  always_comb begin
    cfg_d = cfg_q;
    if (sw_clr_i) begin
      cfg_d.sw_start = 1'b0;
    end
    if (wr_en_i) begin
      cfg_d = wr_cfg;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign div_chg_o  = wr_en_i && ((wr_cfg.div_a != cfg_q.div_a) ||
                                  (wr_cfg.div_b != cfg_q.div_b));
  assign mode_o     = cfg_q.mode;
  assign sw_start_o = cfg_q.sw_start;
  assign repeat_o   = cfg_q.repeat_en;
  assign div_a_o    = cfg_q.div_a;
  assign div_b_o    = cfg_q.div_b;
  assign slow_pre_o = cfg_q.slow_pre;
  assign fast_pre_o = cfg_q.fast_pre;
  assign rd_data_o  = {1'b0, cfg_q};

endmodule

// File: rtl/seq_trig_edge.sv
module seq_trig_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);

  logic [STAGES:0] sync_q, sync_d;

  assign sync_d = {sync_q[STAGES-1:0], lvl_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] && !sync_q[STAGES];

  // R11
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/seq_trig_odd_stage.sv
module seq_trig_odd_stage #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] n_i,
  output logic         wrap_o
);

  logic [W:0] cnt_q, cnt_d, limit;

  assign limit  = {n_i, 1'b0};
  assign wrap_o = en_i && !clr_i && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = (cnt_q == limit) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= limit);

endmodule

// File: rtl/seq_trig_prescale.sv
module seq_trig_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);

  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, mask;

  assign mask   = CNT_W'((1 << sel_i) - 1);
  assign tick_o = en_i && ((cnt_q & mask) == '0);
  assign cnt_d  = en_i ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R10
  pre_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i != '0) |=> (!tick_o || sel_i == '0));

endmodule

// File: rtl/seq_trigger_gen.sv
module seq_trigger_gen
  import seq_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_clk_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             seq_busy_i,
  output logic             start_o,
  output logic             seq_clk_en_o,
  output logic             slow_clk_en_o
);

  localparam int NUM_STAGES = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  trig_mode_e       mode;
  logic             sw_start, repeat_en, div_chg;
  logic [DIV_W-1:0] div_a, div_b;
  logic [PRE_W-1:0] slow_pre, fast_pre;
  logic             slow_tick;
  logic             div_run, sw_run, div_clr;
  logic [NUM_STAGES-1:0] stg_en, stg_wrap;
  logic [DIV_W-1:0] stg_n [NUM_STAGES];
  logic             tog_q, tog_d, div_trig_q, div_trig_d;
  logic             busy_q, sw_trig, rep_fire;
  logic             start_q, start_d;

  // reset: asserted at once, released on a clock edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  seq_trig_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .sw_clr_i   (start_d),
    .mode_o     (mode),
    .sw_start_o (sw_start),
    .repeat_o   (repeat_en),
    .div_a_o    (div_a),
    .div_b_o    (div_b),
    .slow_pre_o (slow_pre),
    .fast_pre_o (fast_pre),
    .div_chg_o  (div_chg),
    .rd_data_o  (rd_data_o)
  );

  seq_trig_edge #(.STAGES(SYNC_STAGES)) u_slow_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .lvl_i  (slow_clk_i),
    .rise_o (slow_tick)
  );

  assign div_run = (mode == MODE_DIV) || (mode == MODE_ANY);
  assign sw_run  = (mode == MODE_SW)  || (mode == MODE_ANY);
  assign div_clr = !div_run || div_chg;

  // cascaded odd-ratio stages: A first, then B
  assign stg_n[0] = div_a;
  assign stg_n[1] = div_b;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign stg_en[g] = slow_tick;
    end else begin : g_tail
      assign stg_en[g] = stg_wrap[g-1];
    end
    seq_trig_odd_stage #(.W(DIV_W)) u_odd (
      .clk_i  (clk_i),
      .rst_ni (rst_n),
      .clr_i  (div_clr),
      .en_i   (stg_en[g]),
      .n_i    (stg_n[g]),
      .wrap_o (stg_wrap[g])
    );
  end

  // final divide-by-two; trigger on its rising edge
  always_comb begin
    tog_d      = div_clr ? 1'b0 : (tog_q ^ stg_wrap[NUM_STAGES-1]);
    div_trig_d = stg_wrap[NUM_STAGES-1] && !tog_q;
  end

  // source mux, busy gating and repeat restart
  always_comb begin
    sw_trig  = sw_run && sw_start && slow_tick;
    rep_fire = repeat_en && busy_q && !seq_busy_i;
    start_d  = (mode != MODE_HALT) && !seq_busy_i &&
               ((div_run && div_trig_q) || sw_trig || rep_fire);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      tog_q      <= 1'b0;
      div_trig_q <= 1'b0;
      busy_q     <= 1'b0;
      start_q    <= 1'b0;
    end else begin
      tog_q      <= tog_d;
      div_trig_q <= div_trig_d;
      busy_q     <= seq_busy_i;
      start_q    <= start_d;
    end
  end

  assign start_o = start_q;

  seq_trig_prescale #(.SEL_W(PRE_W)) u_fast_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .en_i   (1'b1),
    .sel_i  (fast_pre),
    .tick_o (seq_clk_en_o)
  );

  seq_trig_prescale #(.SEL_W(PRE_W)) u_slow_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .en_i   (slow_tick),
    .sel_i  (slow_pre),
    .tick_o (slow_clk_en_o)
  );

  // R4
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $past(mode == MODE_HALT) |-> !start_q);

  // R8
  busy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_q |-> $past(!seq_busy_i));

  // R6
  sw_autoclr_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start_q && !$past(wr_en_i)) |-> !sw_start);

  // R9
  repeat_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $past(repeat_en && mode != MODE_HALT && busy_q && !seq_busy_i) |-> start_q);

  // R12
  div_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    div_trig_q |=> !div_trig_q);

endmodule

// File: tb/seq_trigger_gen_bench.sv
module seq_trigger_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_clk = 1'b0;
  logic        wr_en = 1'b0;
  logic        busy = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        start_o, seq_clk_en, slow_clk_en;

  int checks = 0;
  int fails = 0;
  int slow_cnt = 0;
  int pulse_slow = 0;
  int seed_val;

  seq_trigger_gen u_seq_trigger_gen (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .slow_clk_i    (slow_clk),
    .wr_en_i       (wr_en),
    .wr_data_i     (wr_data),
    .rd_data_o     (rd_data),
    .seq_busy_i    (busy),
    .start_o       (start_o),
    .seq_clk_en_o  (seq_clk_en),
    .slow_clk_en_o (slow_clk_en)
  );

  // 250 MHz fast clock, slow clock at one quarter of it
  always #2 clk = ~clk;
  initial begin
    #1;
    forever begin
      slow_clk = 1'b1; #8;
      slow_clk = 1'b0; #8;
    end
  end
  always @(posedge slow_clk) slow_cnt <= slow_cnt + 1;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ratio(input int a, input int b);
    return (2*a + 1) * (2*b + 1) * 2;
  endfunction

  function automatic logic [15:0] mk(input int r15, input int fs, input int md, input int sw,
                                     input int rp, input int b, input int a, input int sp,
                                     input int fp);
    return {1'(r15), 1'(fs), 2'(md), 1'(sw), 1'(rp), 3'(b), 3'(a), 2'(sp), 2'(fp)};
  endfunction

  task automatic write(input logic [15:0] w);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  // waits for a start pulse; records the slow-edge count and checks width (R12)
  task automatic wait_pulse(input int max_cyc, output int n_cyc);
    n_cyc = -1;
    for (int i = 1; i <= max_cyc; i++) begin
      @(negedge clk);
      if (start_o) begin
        n_cyc = i;
        break;
      end
    end
    if (n_cyc > 0) begin
      pulse_slow = slow_cnt;
      @(negedge clk);
      check(!start_o, "R12 pulse width", int'(start_o), 0);
    end
  endtask

  task automatic quiet(input int cyc, input string req);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (start_o) seen++;
    end
    check(seen == 0, req, seen, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements): got 190000 cycles expected fewer");
    summary();
    $finish;
  end

  initial begin
    int n, s0, r, w, off, a, b, p0, cnt;
    seed_val = int'($urandom(32'd4242));

    // R1: reset state
    repeat (5) @(negedge clk);
    check(rd_data == 16'h0000, "R1 reset readback", int'(rd_data), 0);
    check(start_o == 1'b0, "R1 reset start", int'(start_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rd_data == 16'h0000, "R1 post-reset readback", int'(rd_data), 0);

    // R1: random readback with the trigger source held at halt
    for (int k = 0; k < 8; k++) begin
      w = int'($urandom()) & 32'h0000_CFFF;
      if (k == 0) w = 32'h0000_CFFF | 32'h8000;
      write(16'(w));
      @(negedge clk);
      check(rd_data == 16'(w & 32'h7FFF), "R1 readback", int'(rd_data), w & 32'h7FFF);
    end

    // R10 / R11: prescalers, directed then random selects
    for (int k = 0; k < 8; k++) begin
      int fp = (k < 4) ? k : int'($urandom() % 4);
      int sp = (k < 4) ? 3 - k : int'($urandom() % 4);
      write(mk(0, 0, 0, 0, 0, 0, 0, sp, fp));
      cnt = 0;
      for (int i = 0; i < 64; i++) begin
        @(negedge clk);
        if (seq_clk_en) cnt++;
      end
      check(cnt == (64 >> fp), "R10 fast prescaler", cnt, 64 >> fp);
      cnt = 0;
      for (int i = 0; i < 128; i++) begin
        @(negedge clk);
        if (slow_clk_en) cnt++;
      end
      check(cnt == (32 >> sp), "R11 slow prescaler", cnt, 32 >> sp);
    end

    // R4: halt ignores software start, repeat and busy
    write(mk(0, 0, 0, 1, 1, 0, 0, 0, 0));
    busy = 1'b1;
    repeat (5) @(negedge clk);
    busy = 1'b0;
    quiet(60, "R4 halt");

    // R2 / R3: every (A, B) pair in a seeded order
    off = int'($urandom() % 64);
    for (int idx = 0; idx < 64; idx++) begin
      int p = (idx * 37 + off) % 64;
      a = p % 8;
      b = p / 8;
      r = ratio(a, b);
      write(mk(0, int'($urandom() % 2), 1, 0, 0, b, a, int'($urandom() % 4), int'($urandom() % 4)));
      s0 = slow_cnt;
      wait_pulse((r / 2 + 2) * 4 + 8, n);
      check(n > 0, "R3 first pulse present", n, 1);
      check((pulse_slow - s0) >= r / 2 - 1 && (pulse_slow - s0) <= r / 2,
            "R3 restart latency", pulse_slow - s0, r / 2);
      s0 = pulse_slow;
      wait_pulse(r * 4 + 8, n);
      check(n > 0 && (pulse_slow - s0) == r, "R2 period", pulse_slow - s0, r);
    end

    // R6: software bit inert in divider-only mode, cleared by the next start
    write(mk(0, 0, 1, 1, 0, 7, 7, 0, 0));
    quiet(20, "R6 sw ignored in divider mode");
    check(rd_data[11] == 1'b1, "R6 bit held", int'(rd_data[11]), 1);
    wait_pulse(1000, n);
    check(n > 0, "R6 divider pulse", n, 1);
    check(rd_data[11] == 1'b0, "R6 auto-clear on divider start", int'(rd_data[11]), 0);

    // R5: software start at random phases
    write(mk(0, 0, 2, 1, 0, 0, 0, 0, 0));
    wait_pulse(6, n);
    check(n > 0, "R5 sw start latency", n, 6);
    check(rd_data[11] == 1'b0, "R6 auto-clear on sw start", int'(rd_data[11]), 0);
    quiet(40, "R5 no divider pulses");
    for (int k = 0; k < 4; k++) begin
      repeat (int'($urandom() % 8)) @(negedge clk);
      write(mk(0, 0, 2, 1, 0, 0, 0, 0, 0));
      wait_pulse(6, n);
      check(n > 0, "R5 sw start latency", n, 6);
    end

    // R7: both sources
    write(mk(0, 0, 3, 1, 0, 0, 1, 0, 0));
    wait_pulse(6, n);
    check(n > 0, "R7 sw pulse in either-source mode", n, 6);
    wait_pulse(100, n);
    s0 = pulse_slow;
    wait_pulse(100, n);
    check(n > 0 && (pulse_slow - s0) == 6, "R7 divider period", pulse_slow - s0, 6);

    // R8: busy window straddling a divider trigger
    write(mk(0, 0, 1, 0, 0, 0, 1, 0, 0));
    wait_pulse(200, n);
    wait_pulse(200, n);
    p0 = pulse_slow;
    busy = 1'b1;
    quiet(40, "R8 no pulse while busy");
    busy = 1'b0;
    wait_pulse(60, n);
    check(n > 0 && ((pulse_slow - p0) % 6) == 0, "R8 dropped trigger keeps grid",
          pulse_slow - p0, 12);

    // R9: repeat restarts on falling busy
    write(mk(0, 0, 2, 1, 1, 0, 0, 0, 0));
    wait_pulse(6, n);
    check(n > 0, "R9 initial sw start", n, 6);
    for (int k = 0; k < 3; k++) begin
      busy = 1'b1;
      repeat (3 + int'($urandom() % 8)) @(negedge clk);
      busy = 1'b0;
      @(negedge clk);
      check(start_o == 1'b1, "R9 repeat restart", int'(start_o), 1);
      @(negedge clk);
      check(start_o == 1'b0, "R12 repeat pulse width", int'(start_o), 0);
    end
    write(mk(0, 0, 2, 0, 0, 0, 0, 0, 0));
    busy = 1'b1;
    repeat (5) @(negedge clk);
    busy = 1'b0;
    quiet(20, "R9 no restart without repeat");

    summary();
    $finish;
  end

endmodule